// File: doc/BRIEF.md
# Dual-State Instruction Fetch Controller

This block fetches instructions for a processor that runs either a wide 32-bit instruction set or a compact 16-bit one. It keeps a single state bit that selects the running set. It reads memory through a 16-bit port that uses a request/ready handshake. A wide instruction is built from two beats, and a compact instruction takes one beat. The finished word is held at the output with a width flag and a valid strobe until the consumer asks for the next instruction.

Commands arrive one per cycle on a small command port. The operations are:

- a sequential advance to the next instruction;
- a branch-with-exchange, where bit 0 of the target selects the new state;
- an exception entry, which always lands in wide state at a vector address;
- an exception return, which restores the state from a saved bit that travels with the request.

Each of the last three redirects fetch. A redirect throws away any half-built instruction. The block also outputs the program counter that software sees: the executing instruction's address plus 8 in wide state, or plus 4 in compact state.

Top module: `dual_isa_fetch`

## Requirements
- R1: In reset and on the cycle after it, the outputs are as follows: `compact_state` is 0 (wide state), `insn_valid` is 0, `mem_req` is 1, and `mem_addr` equals the RESET_ADDR parameter (default 0x100).
- R2: A branch-with-exchange (`cmd_op`=1) sets `compact_state` to bit 0 of `cmd_addr`. The next fetch starts at the target with bit 0 cleared in compact state, or with bits 1:0 cleared in wide state.
- R3: An exception entry (`cmd_op`=2) sets `compact_state` to 0 from either state. The next fetch starts at `cmd_addr` with bits 1:0 cleared.
- R4: An exception return (`cmd_op`=3) sets `compact_state` to `cmd_tbit`. The target is aligned as in R2 for that restored state.
- R5: In wide state, an instruction at address A is read in two beats: first at A, then at A+2. `insn_word` is {second beat, first beat}, `insn_wide` is 1, and `insn_valid` rises only after the second beat completes.
- R6: In compact state, an instruction is read in a single beat. `insn_word` is {16'h0000, beat data} and `insn_wide` is 0.
- R7: A beat completes only on a cycle where both `mem_req` and `mem_ready` are high. While it waits, and no redirect arrives, `mem_addr` does not change.
- R8: An advance (`cmd_op`=0) while `insn_valid` is high moves fetch to the next instruction: +4 in wide state, +2 in compact state. An advance while `insn_valid` is low has no effect.
- R9: A redirect that arrives after the first beat of a wide instruction drops that beat. The next request goes to the new target's first address.
- R10: While `insn_valid` is high, `pc_visible` equals the held instruction's address plus 8 in wide state, or plus 4 in compact state.
- R11: While an instruction is held, `mem_req` is low, and `insn_word` and `insn_valid` stay unchanged until an advance or a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 advance, 1 branch-with-exchange, 2 exception entry, 3 exception return |
| cmd_addr | input | ADDR_W | Target, vector or return address |
| cmd_tbit | input | 1 | Saved state bit for an exception return |
| mem_req | output | 1 | Beat request |
| mem_addr | output | ADDR_W | Byte address of the requested halfword |
| mem_ready | input | 1 | Memory completes the beat this cycle |
| mem_rdata | input | 16 | Halfword returned by the beat |
| insn_valid | output | 1 | A whole instruction is held |
| insn_word | output | 32 | Held instruction, zero-extended when compact |
| insn_wide | output | 1 | Held instruction is 32 bits |
| compact_state | output | 1 | 1 in compact 16-bit state, 0 in wide state |
| pc_visible | output | ADDR_W | Software-visible program counter |

## Verification
The assertions check on every cycle the items that depend only on local history:

- the state change each redirect kind causes;
- the alignment of the fetch base;
- address stability during a stalled beat;
- the rule that a wide instruction becomes valid only after a second beat;
- that a held instruction stays unchanged.

Only the bench scenarios can show the data path end to end. They confirm that halves are assembled in little-endian order from the right addresses, and that the visible PC offset follows the state. They also confirm that a half-built word is actually dropped after a redirect, and that an advance with nothing held leaves the fetch address untouched.

// File: rtl/fetch_pkg.sv
// Shared command encoding for the dual-state fetch controller.
package fetch_pkg;
    typedef enum logic [1:0] {
        OP_ADVANCE    = 2'd0,
        OP_BRANCH_X   = 2'd1,
        OP_EXC_ENTER  = 2'd2,
        OP_EXC_RETURN = 2'd3
    } fetch_op_e;
endpackage

// File: rtl/fetch_sequencer.sv
// Holds the instruction-set state bit and the address of the instruction
// being fetched or held. Decodes commands into redirects and advances.
// Assumes that only one command arrives per cycle and that RESET_ADDR is
// word aligned.
module fetch_sequencer
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_tbit,
    input  logic              insn_held,
    output logic              compact_o,
    output logic [ADDR_W-1:0] base_addr_o,
    output logic              redirect_o,
    output logic              advance_o
);
    localparam logic [ADDR_W-1:0] STEP_WIDE    = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_COMPACT = ADDR_W'(2);

    fetch_op_e         op;
    logic              compact_q;
    logic [ADDR_W-1:0] base_q;
    logic              next_compact;
    logic [ADDR_W-1:0] target;

    assign op          = fetch_op_e'(cmd_op);
    assign redirect_o  = cmd_valid && (op != OP_ADVANCE);
    assign advance_o   = cmd_valid && (op == OP_ADVANCE) && insn_held;
    assign compact_o   = compact_q;
    assign base_addr_o = base_q;

    // Work out the new state bit and the aligned target of a redirect.
    always_comb begin
        unique case (op)
            OP_BRANCH_X:   next_compact = cmd_addr[0];
            OP_EXC_ENTER:  next_compact = 1'b0;
            OP_EXC_RETURN: next_compact = cmd_tbit;
            default:       next_compact = compact_q;
        endcase
        if (next_compact)
            target = {cmd_addr[ADDR_W-1:1], 1'b0};
        else
            target = {cmd_addr[ADDR_W-1:2], 2'b00};
    end

    // Update the state bit and the instruction base address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            compact_q <= 1'b0;
            base_q    <= RESET_ADDR;
        end else if (redirect_o) begin
            compact_q <= next_compact;
            base_q    <= target;
        end else if (advance_o) begin
            base_q <= base_q + (compact_q ? STEP_COMPACT : STEP_WIDE);
        end
    end

    assert_bx_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1) |=> (compact_q == $past(cmd_addr[0])) && (base_q[0] == 1'b0));

    assert_exc_wide_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |=> !compact_q && (base_q[1:0] == 2'b00));

    assert_ret_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd3) |=> compact_q == $past(cmd_tbit));

    assert_advance_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0 && insn_held) |=>
            base_q == $past(base_q) + ($past(compact_q) ? STEP_COMPACT : STEP_WIDE));

    assert_advance_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0 && !insn_held) |=> $stable(base_q) && $stable(compact_q));
endmodule

// File: rtl/beat_assembler.sv
// Runs the 16-bit memory handshake and assembles one or two beats into an
// instruction word, which it holds until an advance or a flush. Assumes
// that advance is raised only while a word is held and that base_addr
// changes only on advance or flush.
module beat_assembler #(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                compact,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic                flush,
    input  logic                advance,
    input  logic                mem_ready,
    input  logic [BEAT_W-1:0]   mem_rdata,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                insn_valid,
    output logic [2*BEAT_W-1:0] insn_word,
    output logic                insn_wide
);
    localparam int                INSN_W     = 2 * BEAT_W;
    localparam logic [ADDR_W-1:0] BEAT_BYTES = ADDR_W'(BEAT_W / 8);

    logic              held_q;
    logic              beat_q;
    logic              wide_q;
    logic [BEAT_W-1:0] lo_q;
    logic [INSN_W-1:0] word_q;
    logic              fire;

    assign mem_req    = !held_q;
    assign mem_addr   = base_addr + (beat_q ? BEAT_BYTES : '0);
    assign fire       = mem_req && mem_ready;
    assign insn_valid = held_q;
    assign insn_word  = word_q;
    assign insn_wide  = wide_q;

    // Count beats, collect the halves and hold the finished instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            beat_q <= 1'b0;
            wide_q <= 1'b0;
            lo_q   <= '0;
            word_q <= '0;
        end else if (flush) begin
            held_q <= 1'b0;
            beat_q <= 1'b0;
        end else if (advance) begin
            held_q <= 1'b0;
        end else if (fire) begin
            if (compact) begin
                word_q <= {{BEAT_W{1'b0}}, mem_rdata};
                wide_q <= 1'b0;
                held_q <= 1'b1;
            end else if (!beat_q) begin
                lo_q   <= mem_rdata;
                beat_q <= 1'b1;
            end else begin
                word_q <= {mem_rdata, lo_q};
                wide_q <= 1'b1;
                held_q <= 1'b1;
                beat_q <= 1'b0;
            end
        end
    end

    assert_two_beats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(insn_valid) && insn_wide) |-> $past(beat_q) && $past(mem_ready));

    assert_compact_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !insn_wide) |-> insn_word[INSN_W-1:BEAT_W] == '0);

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !flush) |=> $stable(mem_addr));

    assert_flush_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !insn_valid && (mem_addr == base_addr));

    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !advance && !flush) |=> insn_valid && $stable(insn_word) && !mem_req);
endmodule

// File: rtl/dual_isa_fetch.sv
// Top of the dual-state fetch controller. Joins the state and address
// sequencer to the beat assembler and forms the software-visible PC.
// Assumes a 16-bit memory port and word-aligned RESET_ADDR.
module dual_isa_fetch #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_tbit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [15:0]       mem_rdata,
    output logic              insn_valid,
    output logic [31:0]       insn_word,
    output logic              insn_wide,
    output logic              compact_state,
    output logic [ADDR_W-1:0] pc_visible
);
    localparam int                BEAT_W     = 16;
    localparam logic [ADDR_W-1:0] PC_OFS_WIDE    = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] PC_OFS_COMPACT = ADDR_W'(4);

    logic [ADDR_W-1:0] base_addr;
    logic              redirect;
    logic              advance;

    fetch_sequencer #(
        .ADDR_W     (ADDR_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_tbit    (cmd_tbit),
        .insn_held   (insn_valid),
        .compact_o   (compact_state),
        .base_addr_o (base_addr),
        .redirect_o  (redirect),
        .advance_o   (advance)
    );

    beat_assembler #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W)
    ) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .compact    (compact_state),
        .base_addr  (base_addr),
        .flush      (redirect),
        .advance    (advance),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .insn_wide  (insn_wide)
    );

    // Visible PC runs ahead of the held instruction by the pipeline offset.
    always_comb begin
        pc_visible = base_addr + (compact_state ? PC_OFS_COMPACT : PC_OFS_WIDE);
    end
endmodule

// File: tb/dual_isa_fetch_test.sv
module dual_isa_fetch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_addr = '0;
    logic        cmd_tbit = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata;
    logic        insn_valid;
    logic [31:0] insn_word;
    logic        insn_wide;
    logic        compact_state;
    logic [31:0] pc_visible;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_isa_fetch uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_tbit(cmd_tbit), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .insn_valid(insn_valid), .insn_word(insn_word), .insn_wide(insn_wide),
        .compact_state(compact_state), .pc_visible(pc_visible)
    );

    function automatic logic [15:0] memf(input logic [31:0] a);
        return a[16:1] ^ 16'h3C5A;
    endfunction

    assign mem_rdata = memf(mem_addr);

    function automatic logic [31:0] exp_word(input logic [31:0] a, input logic c);
        return c ? {16'h0000, memf(a)} : {memf(a + 32'd2), memf(a)};
    endfunction

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic        tbit;
        logic        exp_c;
        logic [31:0] exp_a;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd1, 32'h0000_1001, 1'b0, 1'b1, 32'h0000_1000},
        '{2'd2, 32'h0000_001B, 1'b1, 1'b0, 32'h0000_0018},
        '{2'd1, 32'h0000_2003, 1'b0, 1'b1, 32'h0000_2002},
        '{2'd3, 32'h0000_4005, 1'b1, 1'b1, 32'h0000_4004},
        '{2'd2, 32'h0000_0008, 1'b0, 1'b0, 32'h0000_0008},
        '{2'd3, 32'h0000_5006, 1'b0, 1'b0, 32'h0000_5004},
        '{2'd1, 32'h0000_3002, 1'b1, 1'b0, 32'h0000_3000},
        '{2'd1, 32'h0000_7FFF, 1'b0, 1'b1, 32'h0000_7FFE}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [31:0] a, input logic t);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_tbit  = t;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_valid(input string tag);
        int n = 0;
        while (!insn_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(tag, 32'(insn_valid), 32'd1);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog got=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [31:0] hold_w;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 compact in reset", 32'(compact_state), 32'd0);
        chk("R1 valid in reset", 32'(insn_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_addr after reset", mem_addr, 32'h100);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd1);

        // R8: advance with nothing held is ignored
        send(2'd0, 32'h0, 1'b0);
        chk("R8 ignored advance addr", mem_addr, 32'h100);
        chk("R8 ignored advance state", 32'(compact_state), 32'd0);

        // R7: stalled beat keeps address
        repeat (3) @(negedge clk);
        chk("R7 stall addr", mem_addr, 32'h100);
        chk("R7 stall no valid", 32'(insn_valid), 32'd0);

        // R5 R10: first wide instruction from reset address
        mem_ready = 1'b1;
        wait_valid("R5 reset fetch valid");
        chk("R5 reset word", insn_word, exp_word(32'h100, 1'b0));
        chk("R10 reset pc", pc_visible, 32'h108);

        // Vector table: each redirect, then one advance
        for (int i = 0; i < 8; i++) begin
            a = VECS[i].exp_a;
            send(VECS[i].op, VECS[i].addr, VECS[i].tbit);
            chk($sformatf("R2 R3 R4 state vec%0d", i), 32'(compact_state), 32'(VECS[i].exp_c));
            wait_valid($sformatf("R5 R6 valid vec%0d", i));
            chk($sformatf("R5 R6 word vec%0d", i), insn_word, exp_word(a, VECS[i].exp_c));
            chk($sformatf("R5 R6 width vec%0d", i), 32'(insn_wide), 32'(!VECS[i].exp_c));
            chk($sformatf("R10 pc vec%0d", i), pc_visible,
                a + (VECS[i].exp_c ? 32'd4 : 32'd8));
            send(2'd0, 32'h0, 1'b0);
            a = a + (VECS[i].exp_c ? 32'd2 : 32'd4);
            wait_valid($sformatf("R8 next valid vec%0d", i));
            chk($sformatf("R8 next word vec%0d", i), insn_word, exp_word(a, VECS[i].exp_c));
            chk($sformatf("R8 R10 next pc vec%0d", i), pc_visible,
                a + (VECS[i].exp_c ? 32'd4 : 32'd8));
        end

        // R9: redirect after the first beat of a wide fetch
        mem_ready = 1'b0;
        send(2'd1, 32'h8000, 1'b0);
        chk("R2 wide target addr", mem_addr, 32'h8000);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        chk("R5 second beat addr", mem_addr, 32'h8002);
        chk("R5 not valid after one beat", 32'(insn_valid), 32'd0);
        send(2'd1, 32'h9000, 1'b0);
        chk("R9 restart addr", mem_addr, 32'h9000);
        chk("R9 no valid", 32'(insn_valid), 32'd0);
        repeat (2) @(negedge clk);
        chk("R7 stall after redirect", mem_addr, 32'h9000);
        mem_ready = 1'b1;
        wait_valid("R9 new fetch valid");
        chk("R9 new word", insn_word, exp_word(32'h9000, 1'b0));

        // R11: held instruction stays put
        hold_w = insn_word;
        repeat (3) @(negedge clk);
        chk("R11 still valid", 32'(insn_valid), 32'd1);
        chk("R11 no request", 32'(mem_req), 32'd0);
        chk("R11 word stable", insn_word, hold_w);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule